// File: doc/BRIEF.md
# Serial PHY Management Controller

This block lets a host run single management transactions against an Ethernet PHY. The controller drives the management clock (MDC) and the shared bidirectional data line. The data line is brought out as a data-out, output-enable and data-in trio so that the pad can be tri-stated outside the block.

The host works through four small registers selected by `reg_sel`:

- A command register holds the read and write opcode bits and the PHY and register addresses.
- A data register holds the write payload before a write and the returned value after a read.
- A status register holds a busy flag.
- A self-control register holds the MDC divisor, a preamble-suppress bit and a self-clearing soft reset.

A write to the command register starts one frame. The host then polls the busy flag until it clears.

Host writes are always accepted in the cycle `reg_wr` is high. There is no back-pressure on the register port. The busy flag is the only flow control, and a command issued while busy is dropped.

Top module: `mdio_ctl`

## Requirements
- R1: After reset, the status busy bit (select 2, bit 0) reads 0, the data register (select 1) reads 0, `mdc` is low and `mdio_oe` is low.
- R2: Command register (select 0): bit 15 requests a read, bit 14 requests a write, bits 9:5 hold the PHY address and bits 4:0 the register number. Reading it returns the last accepted command, with bits 15 and 14 reduced to the opcode actually run.
- R3: A command write while idle with bit 15 or bit 14 set shows busy = 1 from the next cycle. If both bits are set, a read runs. If neither bit is set, nothing starts.
- R4: Each frame is sent most-significant bit first: 32 ones (unless suppressed), start bits 01, opcode 10 for read or 01 for write, the 5-bit PHY address, the 5-bit register number, two turnaround bits, then 16 data bits. Each bit is sampled by the PHY on a rising MDC edge.
- R5: In a write frame, the turnaround is driven as 1 then 0, followed by the data register value held when the command was written. `mdio_oe` is high for the whole frame.
- R6: In a read frame, `mdio_oe` is low from the first turnaround bit to the end, and the turnaround values on `mdio_i` are ignored. The 16 bits sampled on the following rising MDC edges appear in the data register once busy clears.
- R7: The MDC period is (divisor field + 1) clock cycles, where the divisor field is self-control bits 16:9; a field of 0 gives a period of 2. The divisor is captured when a frame starts, and `mdc` stays low while idle.
- R8: `mdio_o` and `mdio_oe` change only on a falling MDC edge, apart from the first bit placed when the frame starts.
- R9: A frame has exactly 64 rising MDC edges (32 with preamble suppressed). Busy stays high until the falling MDC edge after the last bit.
- R10: A command written while busy is ignored: the frame in flight, its edge count and the command readback are unchanged.
- R11: Writing self-control bit 0 = 1 reads back 1 in the following cycle, then 0. One cycle later still, busy is 0, `mdc` is low and `mdio_oe` is low, and the aborted frame is abandoned.
- R12: Self-control bit 8 = 1 suppresses the preamble, so the frame starts directly with the start bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 command, 1 data, 2 status, 3 self-control |
| reg_wdata | input | 17 | Write data (SC_DIV_LSB + DIV_W bits) |
| reg_rdata | output | 17 | Read data of the selected register (combinational) |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven toward the pad |
| mdio_oe | output | 1 | Output enable for `mdio_o` |

## Verification
Every cycle, the assertions check the following:
- The idle line state: MDC low and the output released.
- That the output bit moves only on falling MDC edges.
- That busy ends only on a falling MDC edge or a soft reset.
- That a soft reset clears busy and MDC in the next cycle.
- That a command written while busy leaves the latched command alone.

The bench scenarios are needed for everything that depends on frame content. This covers the bit order and opcodes, the write turnaround, the release of the line during a read, and the capture of PHY data despite junk in the turnaround. It also covers the measured MDC period for each divisor and the edge count with and without preamble.

// File: rtl/mdio_ctl_pkg.sv
package mdio_ctl_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int FRAME_W    = 32;
  localparam int PRE_W      = 32;
  localparam int CMD_RD_BIT = 15;
  localparam int CMD_WR_BIT = 14;
  localparam int PHY_LSB    = 5;
  localparam int SC_RST_BIT = 0;
  localparam int SC_PRE_BIT = 8;
  localparam int SC_DIV_LSB = 9;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2,
    SEL_SELF = 2'd3
  } reg_sel_e;

  // frame body after the preamble, first bit on the wire in the MSB
  function automatic logic [FRAME_W-1:0] build_frame(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rg,
    input logic [DATA_W-1:0] wd
  );
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [DATA_W-1:0] pay;
    op  = rd ? 2'b10 : 2'b01;
    ta  = rd ? 2'b11 : 2'b10;
    pay = rd ? {DATA_W{1'b0}} : wd;
    return {2'b01, op, phy, rg, ta, pay};
  endfunction
endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
  parameter int DIV_W = 8,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_field,
  output logic             mdc,
  output logic             rise_tk,
  output logic             fall_tk
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] div_eff;
  logic [CNT_W-1:0] half;

  assign div_eff = (div_field == '0) ? CNT_W'(2) : CNT_W'(div_field) + CNT_W'(1);
  assign half    = div_q >> 1;
  assign rise_tk = run && (cnt_q == half - CNT_W'(1));
  assign fall_tk = run && (cnt_q == div_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= CNT_W'(2);
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      div_q <= div_eff;
      mdc   <= 1'b0;
    end else begin
      cnt_q <= fall_tk ? '0 : cnt_q + CNT_W'(1);
      if (rise_tk) mdc <= 1'b1;
      if (fall_tk) mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mgmt_frame.sv
module mgmt_frame
  import mdio_ctl_pkg::*;
#(
  localparam int IDX_W = $clog2(PRE_W + FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic [ADDR_W-1:0] start_phy,
  input  logic [ADDR_W-1:0] start_reg,
  input  logic [DATA_W-1:0] start_wd,
  input  logic              start_pre,
  input  logic              abort,
  input  logic              rise_tk,
  input  logic              fall_tk,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data
);
  logic [FRAME_W-1:0] frm_q;
  logic [FRAME_W-1:0] frm_new;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   last;
  logic [IDX_W-1:0]   plen;
  logic               rd_q, pre_q, samp;

  // {oe, value} of bit i; pre set means the 32 ones are sent
  function automatic logic [1:0] bit_at(input logic [IDX_W-1:0] i, input logic pre,
                                        input logic rd, input logic [FRAME_W-1:0] w);
    logic [IDX_W-1:0] f;
    if (pre && (i < IDX_W'(PRE_W))) return 2'b11;
    f = pre ? i - IDX_W'(PRE_W) : i;
    if (rd && (f >= IDX_W'(14))) return 2'b00;
    return {1'b1, w[5'd31 - f[4:0]]};
  endfunction

  assign frm_new = build_frame(start_rd, start_phy, start_reg, start_wd);
  assign plen    = pre_q ? IDX_W'(PRE_W) : '0;
  assign last    = plen + IDX_W'(FRAME_W - 1);
  assign samp    = rd_q && (idx_q >= plen + IDX_W'(16));
  assign rd_data = frm_q[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      rd_done <= 1'b0;
      idx_q   <= '0;
      frm_q   <= '0;
      rd_q    <= 1'b0;
      pre_q   <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      if (abort) begin
        busy    <= 1'b0;
        mdio_o  <= 1'b0;
        mdio_oe <= 1'b0;
      end else if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          idx_q <= '0;
          frm_q <= frm_new;
          rd_q  <= start_rd;
          pre_q <= !start_pre;
          {mdio_oe, mdio_o} <= bit_at('0, !start_pre, start_rd, frm_new);
        end
      end else begin
        // read payload shifts into the low half of the frame register
        if (rise_tk && samp) frm_q[DATA_W-1:0] <= {frm_q[DATA_W-2:0], mdio_i};
        if (fall_tk) begin
          if (idx_q == last) begin
            busy    <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            rd_done <= rd_q;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
            {mdio_oe, mdio_o} <= bit_at(idx_q + IDX_W'(1), pre_q, rd_q, frm_q);
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_ctl.sv
module mdio_ctl
  import mdio_ctl_pkg::*;
#(
  parameter int DIV_W = 8,
  localparam int HW = SC_DIV_LSB + DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [HW-1:0] reg_wdata,
  output logic [HW-1:0] reg_rdata,
  input  logic          mdio_i,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe
);
  logic              busy, srst_q, cmd_wr, data_wr, sc_wr, go, op_rd, op_wr;
  logic              rise_tk, fall_tk, rd_done;
  logic [DATA_W-1:0] cmd_q, data_q, rd_data;
  logic [DIV_W-1:0]  sc_div;
  logic              sc_pre;

  assign cmd_wr  = reg_wr && (reg_sel == SEL_CMD);
  assign data_wr = reg_wr && (reg_sel == SEL_DATA);
  assign sc_wr   = reg_wr && (reg_sel == SEL_SELF);
  assign op_rd   = reg_wdata[CMD_RD_BIT];
  assign op_wr   = reg_wdata[CMD_WR_BIT] && !op_rd;
  assign go      = cmd_wr && (op_rd || op_wr) && !busy && !srst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      sc_div <= '0;
      sc_pre <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      srst_q <= sc_wr && reg_wdata[SC_RST_BIT];
      if (sc_wr) begin
        sc_div <= reg_wdata[SC_DIV_LSB +: DIV_W];
        sc_pre <= reg_wdata[SC_PRE_BIT];
      end
      if (go)
        cmd_q <= {op_rd, op_wr, 4'b0, reg_wdata[PHY_LSB +: ADDR_W], reg_wdata[ADDR_W-1:0]};
      if (rd_done)      data_q <= rd_data;
      else if (data_wr) data_q <= reg_wdata[DATA_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_CMD:  reg_rdata[DATA_W-1:0] = cmd_q;
      SEL_DATA: reg_rdata[DATA_W-1:0] = data_q;
      SEL_STAT: reg_rdata[0] = busy;
      SEL_SELF: reg_rdata = {sc_div, sc_pre, 7'b0, srst_q};
      default:  reg_rdata = '0;
    endcase
  end

  mdc_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy && !srst_q), .div_field(sc_div),
    .mdc(mdc), .rise_tk(rise_tk), .fall_tk(fall_tk)
  );

  mgmt_frame u_eng (
    .clk(clk), .rst_n(rst_n), .start(go), .start_rd(op_rd),
    .start_phy(reg_wdata[PHY_LSB +: ADDR_W]), .start_reg(reg_wdata[ADDR_W-1:0]),
    .start_wd(data_q), .start_pre(sc_pre), .abort(srst_q),
    .rise_tk(rise_tk), .fall_tk(fall_tk), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_done(rd_done), .rd_data(rd_data)
  );
endmodule

// File: rtl/mdio_ctl_chk.sv
module mdio_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        srst,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        cmd_wr,
  input logic [15:0] cmd_q
);
  // R7
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R8
  out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($fell(mdc) || $past(srst)));

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_q));

  // R11
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!busy && !mdc && !mdio_oe));
endmodule

bind mdio_ctl mdio_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .srst(srst_q), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cmd_wr(cmd_wr), .cmd_q(cmd_q)
);

// File: tb/sim_mdio_ctl.sv
module sim_mdio_ctl;
  localparam int HW = 17;
  logic clk = 0, rst_n = 0, reg_wr = 0, mdio_i = 0;
  logic [1:0] reg_sel = 0;
  logic [HW-1:0] reg_wdata = 0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  mdio_ctl u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

  // PHY model: records the line on rising MDC, answers reads on falling MDC
  int rises = 0, plen_b = 0, per = 0;
  time t_last = 0;
  logic [1:0] cap [0:63];
  logic [15:0] resp = 0;

  always @(posedge mdc) begin
    if (rises < 64) cap[rises] = {mdio_oe, mdio_o};
    if (rises > 0) per = int'(($time - t_last) / 10);
    t_last = $time;
    rises++;
  end

  always @(negedge mdc) begin
    automatic int f = rises - plen_b;
    if (f >= 16 && f <= 31) mdio_i = resp[31 - f];
    else mdio_i = 1'($urandom);
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [HW-1:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [HW-1:0] v);
    @(negedge clk); reg_sel = s; #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [HW-1:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(2, v);
      if (!v[0]) break;
    end
  endtask

  function automatic logic [1:0] exp_bit(input int r, input bit rdop, input logic [4:0] phy,
                                         input logic [4:0] rg, input logic [15:0] wd, input bit pre);
    int f;
    logic [31:0] w;
    if (pre && r < 32) return 2'b11;
    f = pre ? r - 32 : r;
    w = {2'b01, rdop ? 2'b10 : 2'b01, phy, rg, 2'b10, wd};
    if (rdop && f >= 14) return 2'b00;
    return {1'b1, w[31 - f]};
  endfunction

  bit e_rd, e_sup;
  logic [4:0] e_phy, e_rg;
  logic [15:0] e_wd;
  logic [7:0] e_fld;

  task automatic start_txn(input bit rdop, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [7:0] fld, input bit sup, input bit both);
    logic [HW-1:0] v;
    e_rd = rdop; e_phy = phy; e_rg = rg; e_wd = wd; e_fld = fld; e_sup = sup;
    wr(3, {fld, sup, 8'h00});
    if (!rdop) wr(1, {1'b0, wd});
    resp = 16'($urandom);
    plen_b = sup ? 0 : 32;
    rises = 0; per = 0;
    wr(0, {1'b0, both ? 2'b11 : (rdop ? 2'b10 : 2'b01), 4'b0, phy, rg});
    rd(2, v);
    chk(v[0] == 1'b1, "R3 busy after command", v[0], 1);
  endtask

  task automatic finish_txn();
    logic [HW-1:0] v;
    int mism, eff;
    wait_idle();
    chk(rises == (e_sup ? 32 : 64), "R9/R12 rising MDC edge count", rises, e_sup ? 32 : 64);
    mism = 0;
    for (int r = 0; r < (e_sup ? 32 : 64); r++) begin
      automatic logic [1:0] e = exp_bit(r, e_rd, e_phy, e_rg, e_wd, !e_sup);
      if (e[1] == 1'b0) begin
        if (cap[r][1] !== 1'b0) mism++;
      end else if (cap[r] !== e) mism++;
    end
    chk(mism == 0, e_rd ? "R4/R6 read frame bits" : "R4/R5 write frame bits", mism, 0);
    if (e_rd) begin
      rd(1, v);
      chk(v[15:0] == resp, "R6 read data returned", v[15:0], resp);
    end
    eff = (e_fld == 0) ? 2 : int'(e_fld) + 1;
    chk(per == eff, "R7 MDC period", per, eff);
    rd(0, v);
    chk(v[15:0] == {e_rd, !e_rd, 4'b0, e_phy, e_rg}, "R2 command readback", v[15:0],
        {e_rd, !e_rd, 4'b0, e_phy, e_rg});
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
    $finish;
  end

  initial begin
    logic [HW-1:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2, v); chk(v[0] == 1'b0, "R1 busy at reset", v[0], 0);
    rd(1, v); chk(v[15:0] == 16'h0, "R1 data at reset", v[15:0], 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle line", {mdc, mdio_oe}, 0);

    // neither opcode bit: nothing starts
    rises = 0;
    wr(0, 17'h00123);
    repeat (5) @(negedge clk);
    rd(2, v);
    chk(v[0] == 1'b0 && rises == 0, "R3 no-op command", {v[0], rises}, 0);

    // directed: write with preamble, fastest divisor
    start_txn(0, 5'h1f, 5'h00, 16'hA5C3, 8'd0, 0, 0); finish_txn();
    // read with preamble suppressed, divisor 40
    start_txn(1, 5'h01, 5'h01, 16'h0, 8'd39, 1, 0); finish_txn();
    // both opcode bits: read wins
    start_txn(1, 5'h0a, 5'h15, 16'h0, 8'd3, 0, 1); finish_txn();

    // R10: command while busy is dropped
    start_txn(1, 5'h05, 5'h02, 16'h0, 8'd2, 0, 0);
    repeat (20) @(negedge clk);
    wr(0, {1'b0, 2'b01, 4'b0, 5'h1b, 5'h1c});
    finish_txn();

    // R11: soft reset mid-frame
    start_txn(0, 5'h03, 5'h04, 16'h1234, 8'd4, 0, 0);
    repeat (40) @(negedge clk);
    wr(3, {8'd4, 1'b0, 8'h01});
    #1 chk(reg_rdata[0] == 1'b1 || reg_sel != 2'd3, "R11 reset bit reads 1", reg_rdata[0], 1);
    rd(3, v);
    chk(v[0] == 1'b0, "R11 reset bit self-clears", v[0], 0);
    rd(2, v);
    chk(v[0] == 1'b0 && mdc == 1'b0 && mdio_oe == 1'b0, "R11 abort to idle",
        {v[0], mdc, mdio_oe}, 0);

    // random traffic
    for (int k = 0; k < 10; k++) begin
      start_txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                8'($urandom_range(1, 7)), 1'($urandom), 0);
      finish_txn();
    end
    report();
    $finish;
  end
endmodule